// File: doc/BRIEF.md
# Analog memory readout sequencer

Once a sampling matrix has been frozen by a stop event, this block drains it into an event RAM through a single external converter. The matrix is organised as columns of lines. The block walks the columns one after another. Within each column it selects the lines through an analog multiplexer one at a time, strobes the converter and waits for its valid flag. It then writes the converted word into the event RAM.

The walk can begin at column 0 or at the column where acquisition froze, wrapping round the matrix. A window setting can restrict the readout to a contiguous run of columns. While the walk is under way the input amplifiers are held powered down. Completion is reported twice: by a one-cycle interrupt pulse and by a sticky flag that the host polls and then clears. Acquisition stays blocked until the flag has been cleared.

Top module: `amem_readout_seq`

## Requirements
- R1: After reset, `adc_conv`, `ram_we`, `amp_pd`, `irq` and `done_flag` are 0 and `acq_en` is 1.
- R2: A `stop_evt` accepted in an idle cycle with `done_flag` low is followed in the next cycle by `amp_pd`=1, `acq_en`=0 and one `adc_conv` strobe with `mux_sel`=0 (unless the window is empty, see R7).
- R3: Inside a column the lines are converted in order 0 to 19, one strobe each. The next column starts only after line 19. `mux_sel` and `rd_col` stay stable from a strobe until its `adc_valid`.
- R4: The cycle after `adc_valid` is seen while a conversion is pending, `ram_we`=1 with `ram_wdata` equal to that `adc_data` and `ram_addr` = rel*20+line. Here rel is the column's distance from the start column.
- R5: `start_at_stop`=0 makes the start column 0. `start_at_stop`=1 makes it `stop_col`. The physical column `rd_col` = (start+rel) mod 128.
- R6: With `win_en`=0, rel runs from 0 to 125, so 126 columns and 2520 samples are read.
- R7: With `win_en`=1, rel runs from `win_first` for `win_count` columns, clipped so that rel never exceeds 125. If `win_first` ≥ 126 or `win_count`=0 there is no strobe, and `irq` and `done_flag` rise in the cycle after the stop.
- R8: `amp_pd` is 1 throughout a non-empty readout and returns to 0 in the cycle where `done_flag` rises.
- R9: `irq` is a one-cycle pulse that rises with `done_flag`. For a non-empty readout this is the same cycle as the last RAM write.
- R10: `done_flag` holds until `done_clr`, which clears it in the next cycle. `acq_en` is 0 while reading or while `done_flag` is 1. `stop_evt` is ignored in those cycles.
- R11: `adc_valid` arriving when no conversion is pending produces no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_evt | input | 1 | Acquisition-stopped pulse |
| stop_col | input | 7 | Column where acquisition froze |
| start_at_stop | input | 1 | 1: start at stop_col, 0: start at column 0 |
| win_en | input | 1 | Enable windowed readout |
| win_first | input | 7 | First column of window, relative to start |
| win_count | input | 8 | Number of columns in window |
| done_clr | input | 1 | Host clears the done flag |
| adc_data | input | 14 | Converter result |
| adc_valid | input | 1 | Converter result valid |
| mux_sel | output | 5 | Line selected onto the converter |
| rd_col | output | 7 | Physical column being read |
| adc_conv | output | 1 | Convert strobe |
| amp_pd | output | 1 | Input amplifier power-down |
| ram_we | output | 1 | Event RAM write enable |
| ram_addr | output | 12 | Event RAM address |
| ram_wdata | output | 14 | Event RAM write data |
| irq | output | 1 | Completion interrupt pulse |
| done_flag | output | 1 | Sticky completion flag |
| acq_en | output | 1 | Acquisition may run |

## Verification
A stop driven before a clock edge must show its strobe, `mux_sel`=0 and `amp_pd` at the next falling edge. For an empty window, `irq` and `done_flag` must show at that same edge instead. The converter model answers each strobe two cycles later. A monitor records every RAM write at the edge after the corresponding valid, so address and data are compared against the requirement formulas once the readout is complete. The checks on `irq`, `done_flag`, ignored stops and stray valids are all sampled on falling edges, one edge after the cycle in which each result is due.

// File: rtl/rdseq_pkg.sv
// Shared types for the analog memory readout sequencer.
package rdseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;
endpackage

// File: rtl/rdseq_window.sv
// Window resolver: turns the mode and window settings into a first relative
// column, a last relative column and an empty indication. The start column
// and the last column are latched when a readout is accepted.
// Assumes VALID_COLS <= NUM_COLS and that NUM_COLS fits in COL_W+1 bits.
module rdseq_window #(
    parameter int NUM_COLS   = 128,
    parameter int VALID_COLS = 126,
    localparam int COL_W     = $clog2(NUM_COLS),
    localparam int CNT_W     = COL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             start_at_stop_i,
    input  logic [COL_W-1:0] stop_col_i,
    input  logic             win_en_i,
    input  logic [COL_W-1:0] win_first_i,
    input  logic [CNT_W-1:0] win_count_i,
    output logic [COL_W-1:0] first_o,
    output logic             empty_o,
    output logic [COL_W-1:0] start_col_o,
    output logic [COL_W-1:0] last_col_o
);
    localparam logic [CNT_W-1:0] VC = CNT_W'(VALID_COLS);

    logic [CNT_W-1:0] first_ext;
    logic [CNT_W-1:0] avail;
    logic [CNT_W-1:0] cnt;
    logic [COL_W-1:0] last_c;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] last_q;

    // Clip the requested window to the valid columns.
    always_comb begin
        first_ext = win_en_i ? {1'b0, win_first_i} : '0;
        avail     = '0;
        if (!win_en_i) begin
            cnt = VC;
        end else if (first_ext >= VC) begin
            cnt = '0;
        end else begin
            avail = VC - first_ext;
            cnt   = (win_count_i < avail) ? win_count_i : avail;
        end
        last_c = COL_W'(first_ext + cnt - CNT_W'(1));
    end

    assign first_o = first_ext[COL_W-1:0];
    assign empty_o = (cnt == '0);

    // Latch start column and last relative column on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            last_q  <= '0;
        end else if (load_i) begin
            start_q <= start_at_stop_i ? stop_col_i : '0;
            last_q  <= last_c;
        end
    end

    assign start_col_o = start_q;
    assign last_col_o  = last_q;

    // R7: a latched window never runs past the last valid column.
    p_window_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !empty_o) |=> (CNT_W'(last_col_o) < VC));
endmodule

// File: rtl/rdseq_addr.sv
// Position counters and event RAM write port. Holds the current line and
// relative column, derives the physical column with wrap-around, and
// registers one RAM write per accepted converter result.
// Assumes step_i only pulses while a conversion is pending.
module rdseq_addr #(
    parameter int NUM_COLS  = 128,
    parameter int NUM_LINES = 20,
    parameter int ADC_W     = 14,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int CNT_W    = COL_W + 1,
    localparam int LINE_W   = $clog2(NUM_LINES),
    localparam int ADDR_W   = $clog2(NUM_COLS * NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [COL_W-1:0]  first_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [COL_W-1:0]  last_col_i,
    input  logic              step_i,
    input  logic [ADC_W-1:0]  adc_data_i,
    output logic [LINE_W-1:0] line_o,
    output logic [COL_W-1:0]  col_phys_o,
    output logic              last_sample_o,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [ADC_W-1:0]  ram_wdata_o
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    logic [LINE_W-1:0] line_q;
    logic [COL_W-1:0]  col_q;
    logic [CNT_W-1:0]  phys_sum;
    logic [ADDR_W-1:0] addr_c;

    // Walk lines within a column, then move to the next column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            col_q  <= '0;
        end else if (load_i) begin
            line_q <= '0;
            col_q  <= first_i;
        end else if (step_i) begin
            if (line_q == LAST_LINE) begin
                line_q <= '0;
                col_q  <= col_q + COL_W'(1);
            end else begin
                line_q <= line_q + LINE_W'(1);
            end
        end
    end

    // Physical column = start + relative, modulo the column count.
    always_comb begin
        phys_sum = {1'b0, start_col_i} + {1'b0, col_q};
        if (phys_sum >= CNT_W'(NUM_COLS)) begin
            phys_sum = phys_sum - CNT_W'(NUM_COLS);
        end
    end

    assign col_phys_o    = phys_sum[COL_W-1:0];
    assign line_o        = line_q;
    assign last_sample_o = (line_q == LAST_LINE) && (col_q == last_col_i);
    assign addr_c        = ADDR_W'(col_q) * ADDR_W'(NUM_LINES) + ADDR_W'(line_q);

    // Register one RAM write per accepted converter result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
        end else begin
            ram_we_o <= step_i;
            if (step_i) begin
                ram_addr_o  <= addr_c;
                ram_wdata_o <= adc_data_i;
            end
        end
    end

    // R4: every write carries the data presented with the accepted result.
    p_wdata_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (ram_we_o && ram_wdata_o == $past(adc_data_i)));
    // R3: line index stays below the line count.
    p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        line_q <= LAST_LINE);
endmodule

// File: rtl/rdseq_ctrl.sv
// Readout control FSM: accepts a stop, issues one convert strobe per sample,
// waits for the converter, and finishes with an interrupt pulse and a sticky
// done flag. Drives amplifier power-down for the whole readout.
// Assumes the converter answers every strobe with exactly one valid.
module rdseq_ctrl
    import rdseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_evt_i,
    input  logic empty_i,
    input  logic adc_valid_i,
    input  logic last_sample_i,
    input  logic done_clr_i,
    output logic load_o,
    output logic step_o,
    output logic adc_conv_o,
    output logic amp_pd_o,
    output logic irq_o,
    output logic done_o,
    output logic acq_en_o
);
    seq_state_t state_q;
    logic       finish;

    assign acq_en_o   = (state_q == ST_IDLE) && !done_o;
    assign load_o     = acq_en_o && stop_evt_i;
    assign step_o     = (state_q == ST_WAIT) && adc_valid_i;
    assign adc_conv_o = (state_q == ST_CONV);
    assign finish     = (load_o && empty_i) || (step_o && last_sample_i);

    // Sequence state: idle, strobe, wait for the converter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (load_o && !empty_i) state_q <= ST_CONV;
                ST_CONV: state_q <= ST_WAIT;
                ST_WAIT: if (step_o) state_q <= last_sample_i ? ST_IDLE : ST_CONV;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Amplifier power-down spans the non-empty readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amp_pd_o <= 1'b0;
        end else if (load_o && !empty_i) begin
            amp_pd_o <= 1'b1;
        end else if (finish) begin
            amp_pd_o <= 1'b0;
        end
    end

    // Completion pulse and sticky flag; finishing wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            irq_o <= finish;
            if (finish) begin
                done_o <= 1'b1;
            end else if (done_clr_i) begin
                done_o <= 1'b0;
            end
        end
    end

    // R9: interrupt lasts one cycle.
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R9: interrupt only alongside the done flag.
    p_irq_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);
    // R8: converter strobes only while amplifiers are powered down.
    p_pd_during_conv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv_o |-> amp_pd_o);
    // R10: done holds until the host clears it.
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !done_clr_i) |=> done_o);
    // R10: acquisition blocked while done is pending.
    p_acq_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !acq_en_o);
    // R3: one strobe per conversion.
    p_conv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv_o |=> !adc_conv_o);
endmodule

// File: rtl/amem_readout_seq.sv
// Analog memory readout sequencer top: ties the window resolver, the
// position counters with RAM write port, and the control FSM together.
// Assumes one converter result per strobe and an event RAM that accepts a
// write every cycle.
module amem_readout_seq #(
    parameter int NUM_COLS   = 128,
    parameter int NUM_LINES  = 20,
    parameter int VALID_COLS = 126,
    parameter int ADC_W      = 14,
    localparam int COL_W     = $clog2(NUM_COLS),
    localparam int CNT_W     = COL_W + 1,
    localparam int LINE_W    = $clog2(NUM_LINES),
    localparam int ADDR_W    = $clog2(NUM_COLS * NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_evt,
    input  logic [COL_W-1:0]  stop_col,
    input  logic              start_at_stop,
    input  logic              win_en,
    input  logic [COL_W-1:0]  win_first,
    input  logic [CNT_W-1:0]  win_count,
    input  logic              done_clr,
    input  logic [ADC_W-1:0]  adc_data,
    input  logic              adc_valid,
    output logic [LINE_W-1:0] mux_sel,
    output logic [COL_W-1:0]  rd_col,
    output logic              adc_conv,
    output logic              amp_pd,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [ADC_W-1:0]  ram_wdata,
    output logic              irq,
    output logic              done_flag,
    output logic              acq_en
);
    logic             load;
    logic             step;
    logic             empty;
    logic             last_sample;
    logic [COL_W-1:0] first_rel;
    logic [COL_W-1:0] start_col;
    logic [COL_W-1:0] last_rel;

    rdseq_window #(
        .NUM_COLS   (NUM_COLS),
        .VALID_COLS (VALID_COLS)
    ) u_window (
        .clk             (clk),
        .rst_n           (rst_n),
        .load_i          (load),
        .start_at_stop_i (start_at_stop),
        .stop_col_i      (stop_col),
        .win_en_i        (win_en),
        .win_first_i     (win_first),
        .win_count_i     (win_count),
        .first_o         (first_rel),
        .empty_o         (empty),
        .start_col_o     (start_col),
        .last_col_o      (last_rel)
    );

    rdseq_addr #(
        .NUM_COLS  (NUM_COLS),
        .NUM_LINES (NUM_LINES),
        .ADC_W     (ADC_W)
    ) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .first_i       (first_rel),
        .start_col_i   (start_col),
        .last_col_i    (last_rel),
        .step_i        (step),
        .adc_data_i    (adc_data),
        .line_o        (mux_sel),
        .col_phys_o    (rd_col),
        .last_sample_o (last_sample),
        .ram_we_o      (ram_we),
        .ram_addr_o    (ram_addr),
        .ram_wdata_o   (ram_wdata)
    );

    rdseq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_evt_i    (stop_evt),
        .empty_i       (empty),
        .adc_valid_i   (adc_valid),
        .last_sample_i (last_sample),
        .done_clr_i    (done_clr),
        .load_o        (load),
        .step_o        (step),
        .adc_conv_o    (adc_conv),
        .amp_pd_o      (amp_pd),
        .irq_o         (irq),
        .done_o        (done_flag),
        .acq_en_o      (acq_en)
    );

    // R3: selection held between a strobe and the next cycle.
    p_mux_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv |=> ($stable(mux_sel) && $stable(rd_col)));
    // R11: a RAM write always follows a converter valid.
    p_we_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(adc_valid));
    // R8: amplifiers released when done rises.
    p_pd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !amp_pd);
endmodule

// File: tb/amem_readout_seq_tb.sv
// Directed bench for the readout sequencer with a two-cycle converter model.
module amem_readout_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop_evt = 1'b0;
    logic [6:0]  stop_col = '0;
    logic        start_at_stop = 1'b0;
    logic        win_en = 1'b0;
    logic [6:0]  win_first = '0;
    logic [7:0]  win_count = '0;
    logic        done_clr = 1'b0;
    logic [13:0] adc_data;
    logic        adc_valid;
    logic [4:0]  mux_sel;
    logic [6:0]  rd_col;
    logic        adc_conv, amp_pd, ram_we, irq, done_flag, acq_en;
    logic [11:0] ram_addr;
    logic [13:0] ram_wdata;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    amem_readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .stop_evt(stop_evt), .stop_col(stop_col),
        .start_at_stop(start_at_stop), .win_en(win_en), .win_first(win_first),
        .win_count(win_count), .done_clr(done_clr), .adc_data(adc_data),
        .adc_valid(adc_valid), .mux_sel(mux_sel), .rd_col(rd_col),
        .adc_conv(adc_conv), .amp_pd(amp_pd), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq(irq),
        .done_flag(done_flag), .acq_en(acq_en)
    );

    // Converter model: answers a strobe two cycles later.
    function automatic logic [13:0] sample_val(input int col, input int line);
        return 14'(((col * 20 + line) ^ 'h15A3) & 'h3FFF);
    endfunction

    logic        cv1 = 1'b0, mv = 1'b0, stray = 1'b0;
    logic [13:0] cd1 = '0, md = '0;
    always @(posedge clk) begin
        cv1 <= adc_conv;
        cd1 <= sample_val(int'(rd_col), int'(mux_sel));
        mv  <= cv1;
        md  <= cd1;
    end
    assign adc_valid = mv | stray;
    assign adc_data  = md;

    // Monitor: RAM contents by epoch, event counters.
    logic [13:0] mem_d [2560];
    int          mem_e [2560];
    int epoch = 0;
    int wr_cnt = 0, conv_cnt = 0, irq_cnt = 0;
    bit irq_with_we = 0;
    always @(posedge clk) begin
        if (ram_we) begin
            mem_d[ram_addr] <= ram_wdata;
            mem_e[ram_addr] <= epoch;
            wr_cnt <= wr_cnt + 1;
        end
        if (adc_conv) conv_cnt <= conv_cnt + 1;
        if (irq) begin
            irq_cnt <= irq_cnt + 1;
            irq_with_we <= ram_we;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic test_reset();
        @(negedge clk);
        check(adc_conv == 0 && ram_we == 0 && amp_pd == 0, "R1 outputs idle",
              {adc_conv, ram_we, amp_pd}, 0);
        check(irq == 0 && done_flag == 0 && acq_en == 1, "R1 flags",
              {irq, done_flag, acq_en}, 1);
    endtask

    task automatic test_stray_valid();
        int w0;
        w0 = wr_cnt;
        @(negedge clk) stray = 1;
        @(negedge clk) stray = 0;
        @(negedge clk);
        check(wr_cnt == w0 && ram_we == 0, "R11 stray valid ignored", wr_cnt - w0, 0);
    endtask

    // One readout with given settings; exp_first/exp_cnt from R5..R7.
    task automatic run_case(input string name, input bit from_stop, input int scol,
                            input bit wen, input int wf, input int wc,
                            input int exp_first, input int exp_cnt, input bit poke);
        int w0, c0, i0, start, bad, t, c1;
        epoch++;
        w0 = wr_cnt; c0 = conv_cnt; i0 = irq_cnt;
        start = from_stop ? scol : 0;
        @(negedge clk);
        start_at_stop = from_stop; stop_col = 7'(scol);
        win_en = wen; win_first = 7'(wf); win_count = 8'(wc);
        stop_evt = 1;
        @(negedge clk);
        stop_evt = 0;
        if (exp_cnt > 0) begin
            check(adc_conv == 1 && mux_sel == 0 && amp_pd == 1 && acq_en == 0,
                  {"R2 first strobe ", name}, {adc_conv, amp_pd, acq_en}, 6);
            check(int'(rd_col) == (start + exp_first) % 128,
                  {"R5 first column ", name}, rd_col, (start + exp_first) % 128);
        end else begin
            check(adc_conv == 0 && irq == 1 && done_flag == 1,
                  {"R7 empty window done ", name}, {adc_conv, irq, done_flag}, 3);
        end
        if (poke) begin
            repeat (40) @(negedge clk);
            stop_col = 7'((scol + 33) % 128); stop_evt = 1;
            @(negedge clk) stop_evt = 0;
        end
        t = 0;
        while (!done_flag && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(done_flag == 1, {"R9 done raised ", name}, done_flag, 1);
        @(negedge clk);
        check(wr_cnt - w0 == exp_cnt * 20, {"R6 R7 write count ", name},
              wr_cnt - w0, exp_cnt * 20);
        check(conv_cnt - c0 == exp_cnt * 20, {"R3 strobe count ", name},
              conv_cnt - c0, exp_cnt * 20);
        bad = 0;
        for (int a = 0; a < 2560; a++) begin
            int rel, ln;
            bit want;
            rel = a / 20; ln = a % 20;
            want = (rel >= exp_first) && (rel < exp_first + exp_cnt);
            if (want) begin
                if (mem_e[a] != epoch || mem_d[a] != sample_val((start + rel) % 128, ln)) bad++;
            end else if (mem_e[a] == epoch) begin
                bad++;
            end
        end
        check(bad == 0, {"R4 R5 RAM content ", name}, bad, 0);
        check(irq_cnt - i0 == 1 && irq == 0, {"R9 single irq ", name}, irq_cnt - i0, 1);
        if (exp_cnt > 0)
            check(irq_with_we == 1, {"R9 irq with last write ", name}, irq_with_we, 1);
        check(amp_pd == 0 && acq_en == 0, {"R8 R10 after done ", name}, {amp_pd, acq_en}, 0);
        // R10: stop ignored while done pending.
        c1 = conv_cnt;
        stop_evt = 1;
        @(negedge clk) stop_evt = 0;
        repeat (6) @(negedge clk);
        check(conv_cnt == c1 && done_flag == 1 && amp_pd == 0,
              {"R10 stop ignored while done ", name}, conv_cnt - c1, 0);
        done_clr = 1;
        @(negedge clk) done_clr = 0;
        check(done_flag == 0 && acq_en == 1, {"R10 clear ", name}, {done_flag, acq_en}, 1);
    endtask

    initial begin
        for (int a = 0; a < 2560; a++) begin
            mem_e[a] = -1;
            mem_d[a] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        test_reset();
        test_stray_valid();
        run_case("full from 0", 0, 77, 0, 0, 0, 0, 126, 1);
        run_case("full from stop wrap", 1, 100, 0, 0, 0, 0, 126, 1);
        run_case("window small", 1, 120, 1, 10, 5, 10, 5, 0);
        run_case("window clipped", 0, 0, 1, 120, 50, 120, 6, 0);
        run_case("window empty start", 1, 3, 1, 126, 4, 0, 0, 0);
        run_case("window zero count", 0, 0, 1, 5, 0, 0, 0, 0);
        test_stray_valid();
        summary();
    end
endmodule